// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block refills a translation cache after a miss. It takes a 20-bit virtual page number and resolves it against a two-level table tree in physical memory. The upper ten bits of the page number select a word in the top table. That word is the physical base of a leaf table, and the lower ten bits select the leaf entry inside it. The block returns the physical page number, the read/write/execute permissions and the dirty flag. If the top-level word is zero, or the leaf entry is marked invalid, it returns a fault instead.

The tree base is a software-written register inside the block. Table reads leave through a single request/acknowledge read port whose latency may vary. The block accepts one walk at a time. It signals readiness, and it presents every result for a single cycle.

Top module: `pgtbl_walker`

## Requirements
- R1: `walk_ready` is high only while no walk is in progress; `walk_req` is accepted on a clock edge where `walk_ready` is high, and a request raised while `walk_ready` is low is ignored and changes neither the memory reads nor the result of the walk in flight.
- R2: In the cycle after acceptance, `mem_req` is high and `mem_addr` equals the tree base plus four times `walk_vpn[19:10]`.
- R3: While `mem_req` is high and `mem_ack` is low, `mem_req` stays high and `mem_addr` keeps its value in the next cycle, for any latency.
- R4: If the word returned for the top-level read is zero, no second read is issued; `walk_done` rises with `walk_fault` high in the cycle after that acknowledge.
- R5: If the top-level word is non-zero, the cycle after its acknowledge issues a leaf read at that word plus four times `walk_vpn[9:0]`.
- R6: A leaf entry uses bit 0 valid, bit 1 dirty, bit 2 read, bit 3 write, bit 4 execute, bits [31:12] page number. When valid is set, the result carries `walk_fault` low, `walk_ppn` = bits [31:12], `walk_perm` = bits [4:2] (bit 0 read, bit 1 write, bit 2 execute) and `walk_dirty` = bit 1.
- R7: When the leaf entry's valid bit is clear, the result carries `walk_fault` high and `walk_ppn`, `walk_perm` and `walk_dirty` at zero, whatever the other entry bits hold.
- R8: `walk_done` is high for exactly one cycle, the cycle after the last acknowledge of the walk; `walk_ready` is high in the cycle after that; all result outputs are zero whenever `walk_done` is low.
- R9: `root_we` loads `root_wdata` into the tree base (zero after reset). A write on the same edge that accepts a walk takes effect only for later walks.
- R10: While reset is asserted, `walk_ready` is high and `mem_req` and `walk_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_we | input | 1 | Load the tree base register |
| root_wdata | input | 32 | New tree base (physical address) |
| walk_req | input | 1 | Start a walk |
| walk_vpn | input | 20 | Virtual page number to resolve |
| walk_ready | output | 1 | Block idle, request will be taken |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 32 | Physical byte address of the table word |
| mem_ack | input | 1 | Read data valid, request completed |
| mem_rdata | input | 32 | Table word read |
| walk_done | output | 1 | Result valid for one cycle |
| walk_fault | output | 1 | Page not mapped |
| walk_ppn | output | 20 | Physical page number |
| walk_perm | output | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| walk_dirty | output | 1 | Dirty flag of the entry |

## Verification
A tree-base write can land on the same clock edge that accepts a walk. A new request can also arrive while a walk is still in flight. The bench drives `root_we` together with `walk_req`, with a different base that has its own tables. It then checks that the first walk resolves through the old tables and the following walk through the new ones. It also pulses a request for an unmapped page in the middle of a slow walk, and requires that the read count and the returned entry match the original walk alone. A cycle-by-cycle reference model judges every output in every cycle, and these collisions are judged the same way.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD1,
      ST_WT1,
      ST_RD2,
      ST_WT2,
      ST_DONE
   } walk_st_e;

   localparam int unsigned F_VALID = 0;
   localparam int unsigned F_DIRTY = 1;
   localparam int unsigned F_READ  = 2;
   localparam int unsigned F_WRITE = 3;
   localparam int unsigned F_EXEC  = 4;

   typedef struct packed {
      logic x;
      logic w;
      logic r;
   } perm_t;

endpackage

// File: rtl/pgw_root_reg.sv
module pgw_root_reg #(
   parameter int unsigned PA_W = 32,
   parameter logic [PA_W-1:0] RESET_VAL = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [PA_W-1:0] wdata,
   output logic [PA_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RESET_VAL;
      else if (we) q <= wdata;
   end

endmodule

// File: rtl/pgw_addr_form.sv
module pgw_addr_form #(
   parameter int unsigned PA_W     = 32,
   parameter int unsigned IDX_W    = 10,
   parameter int unsigned ENTRY_SH = 2,
   parameter bit          ALIGNED  = 1'b0
) (
   input  logic [PA_W-1:0]  base,
   input  logic [IDX_W-1:0] idx,
   output logic [PA_W-1:0]  addr
);

   localparam int unsigned OFS_W = IDX_W + ENTRY_SH;

   logic [OFS_W-1:0] ofs;
   assign ofs = OFS_W'(idx) << ENTRY_SH;

   generate
      if (ALIGNED) begin : g_splice
         logic [OFS_W-1:0] unused_base_low;
         assign unused_base_low = base[OFS_W-1:0];
         assign addr = {base[PA_W-1:OFS_W], ofs};
      end else begin : g_add
         assign addr = base + PA_W'(ofs);
      end
   endgenerate

endmodule

// File: rtl/pgw_entry_decode.sv
module pgw_entry_decode
   import pgw_pkg::*;
#(
   parameter int unsigned PA_W       = 32,
   parameter int unsigned PAGE_OFS_W = 12
) (
   input  logic [PA_W-1:0]            entry,
   output logic                       valid,
   output logic                       dirty,
   output perm_t                      perm,
   output logic [PA_W-PAGE_OFS_W-1:0] ppn
);

   assign valid  = entry[F_VALID];
   assign dirty  = entry[F_DIRTY];
   assign perm.r = entry[F_READ];
   assign perm.w = entry[F_WRITE];
   assign perm.x = entry[F_EXEC];
   assign ppn    = entry[PA_W-1:PAGE_OFS_W];

   generate
      if (PAGE_OFS_W > F_EXEC + 1) begin : g_spare
         logic [PAGE_OFS_W-F_EXEC-2:0] unused_spare;
         assign unused_spare = entry[PAGE_OFS_W-1:F_EXEC+1];
      end
   endgenerate

endmodule

// File: rtl/pgtbl_walker.sv
module pgtbl_walker
   import pgw_pkg::*;
#(
   parameter int unsigned PA_W        = 32,
   parameter int unsigned VPN_W       = 20,
   parameter int unsigned L1_IDX_W    = 10,
   parameter int unsigned PAGE_OFS_W  = 12,
   parameter int unsigned ENTRY_BYTES = 4,
   parameter bit          ALIGNED     = 1'b0,
   parameter logic [PA_W-1:0] ROOT_RESET = '0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       root_we,
   input  logic [PA_W-1:0]            root_wdata,
   input  logic                       walk_req,
   input  logic [VPN_W-1:0]           walk_vpn,
   output logic                       walk_ready,
   output logic                       mem_req,
   output logic [PA_W-1:0]            mem_addr,
   input  logic                       mem_ack,
   input  logic [PA_W-1:0]            mem_rdata,
   output logic                       walk_done,
   output logic                       walk_fault,
   output logic [PA_W-PAGE_OFS_W-1:0] walk_ppn,
   output logic [2:0]                 walk_perm,
   output logic                       walk_dirty
);

   localparam int unsigned L2_IDX_W = VPN_W - L1_IDX_W;
   localparam int unsigned ENTRY_SH = $clog2(ENTRY_BYTES);
   localparam int unsigned PPN_W    = PA_W - PAGE_OFS_W;

   generate
      if (VPN_W <= L1_IDX_W) begin : g_bad_split
         $error("VPN_W must exceed L1_IDX_W");
      end
      if ((1 << ENTRY_SH) != ENTRY_BYTES || ENTRY_BYTES < 2) begin : g_bad_entry
         $error("ENTRY_BYTES must be a power of two, at least 2");
      end
      if (L2_IDX_W + ENTRY_SH > PAGE_OFS_W) begin : g_bad_leaf
         $error("leaf table must fit within one page");
      end
      if (L1_IDX_W + ENTRY_SH > PAGE_OFS_W) begin : g_bad_top
         $error("top table must fit within one page");
      end
      if (PAGE_OFS_W <= F_EXEC || PA_W <= PAGE_OFS_W) begin : g_bad_fields
         $error("entry has no room for its flag bits or page number");
      end
   endgenerate

   walk_st_e               st_q;
   logic [PA_W-1:0]        root_q;
   logic [PA_W-1:0]        addr_q;
   logic [L2_IDX_W-1:0]    leaf_idx_q;
   logic [PA_W-1:0]        top_addr;
   logic [PA_W-1:0]        leaf_addr;
   logic                   ent_valid;
   logic                   ent_dirty;
   perm_t                  ent_perm;
   logic [PPN_W-1:0]       ent_ppn;
   logic                   res_fault_q;
   logic                   res_dirty_q;
   perm_t                  res_perm_q;
   logic [PPN_W-1:0]       res_ppn_q;
   logic                   top_phase;
   logic                   leaf_phase;
   logic                   accept;

   pgw_root_reg #(
      .PA_W      (PA_W),
      .RESET_VAL (ROOT_RESET)
   ) u_root (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (root_we),
      .wdata (root_wdata),
      .q     (root_q)
   );

   pgw_addr_form #(
      .PA_W     (PA_W),
      .IDX_W    (L1_IDX_W),
      .ENTRY_SH (ENTRY_SH),
      .ALIGNED  (ALIGNED)
   ) u_top_addr (
      .base (root_q),
      .idx  (walk_vpn[VPN_W-1:L2_IDX_W]),
      .addr (top_addr)
   );

   pgw_addr_form #(
      .PA_W     (PA_W),
      .IDX_W    (L2_IDX_W),
      .ENTRY_SH (ENTRY_SH),
      .ALIGNED  (ALIGNED)
   ) u_leaf_addr (
      .base (mem_rdata),
      .idx  (leaf_idx_q),
      .addr (leaf_addr)
   );

   pgw_entry_decode #(
      .PA_W       (PA_W),
      .PAGE_OFS_W (PAGE_OFS_W)
   ) u_decode (
      .entry (mem_rdata),
      .valid (ent_valid),
      .dirty (ent_dirty),
      .perm  (ent_perm),
      .ppn   (ent_ppn)
   );

   assign top_phase  = (st_q == ST_RD1) || (st_q == ST_WT1);
   assign leaf_phase = (st_q == ST_RD2) || (st_q == ST_WT2);
   assign accept     = (st_q == ST_IDLE) && walk_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         addr_q      <= '0;
         leaf_idx_q  <= '0;
         res_fault_q <= 1'b0;
         res_dirty_q <= 1'b0;
         res_perm_q  <= '0;
         res_ppn_q   <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  addr_q     <= top_addr;
                  leaf_idx_q <= walk_vpn[L2_IDX_W-1:0];
                  st_q       <= ST_RD1;
               end
            end
            ST_RD1, ST_WT1: begin
               if (mem_ack) begin
                  if (mem_rdata == '0) begin
                     res_fault_q <= 1'b1;
                     res_dirty_q <= 1'b0;
                     res_perm_q  <= '0;
                     res_ppn_q   <= '0;
                     st_q        <= ST_DONE;
                  end else begin
                     addr_q <= leaf_addr;
                     st_q   <= ST_RD2;
                  end
               end else begin
                  st_q <= ST_WT1;
               end
            end
            ST_RD2, ST_WT2: begin
               if (mem_ack) begin
                  res_fault_q <= !ent_valid;
                  res_dirty_q <= ent_valid & ent_dirty;
                  res_perm_q  <= ent_valid ? ent_perm : '0;
                  res_ppn_q   <= ent_valid ? ent_ppn : '0;
                  st_q        <= ST_DONE;
               end else begin
                  st_q <= ST_WT2;
               end
            end
            ST_DONE: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign walk_ready = (st_q == ST_IDLE);
   assign mem_req    = top_phase || leaf_phase;
   assign mem_addr   = addr_q;
   assign walk_done  = (st_q == ST_DONE);
   assign walk_fault = walk_done & res_fault_q;
   assign walk_dirty = walk_done & res_dirty_q;
   assign walk_perm  = walk_done ? res_perm_q : 3'b000;
   assign walk_ppn   = walk_done ? res_ppn_q : '0;

endmodule

// File: rtl/pgtbl_walker_chk.sv
module pgtbl_walker_chk #(
   parameter int unsigned PA_W       = 32,
   parameter int unsigned VPN_W      = 20,
   parameter int unsigned L1_IDX_W   = 10,
   parameter int unsigned PAGE_OFS_W = 12,
   parameter bit          ALIGNED    = 1'b0
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [PA_W-1:0]            root_q,
   input logic                       walk_req,
   input logic [VPN_W-1:0]           walk_vpn,
   input logic                       walk_ready,
   input logic                       mem_req,
   input logic [PA_W-1:0]            mem_addr,
   input logic                       mem_ack,
   input logic [PA_W-1:0]            mem_rdata,
   input logic                       walk_done,
   input logic                       walk_fault,
   input logic [PA_W-PAGE_OFS_W-1:0] walk_ppn,
   input logic [2:0]                 walk_perm,
   input logic                       walk_dirty
);

   logic       took;
   logic [1:0] acks_q;
   logic [PA_W-1:0] top_exp;

   assign took    = walk_req && walk_ready;
   assign top_exp = root_q + (PA_W'(walk_vpn[VPN_W-1:VPN_W-L1_IDX_W]) << 2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  acks_q <= 2'd0;
      else if (took)               acks_q <= 2'd0;
      else if (mem_req && mem_ack) acks_q <= acks_q + 2'd1;
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      walk_ready |-> !mem_req && !walk_done); // R1

   AST_TOP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      took |=> mem_req && (ALIGNED || mem_addr == $past(top_exp))); // R2

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr)); // R3

   AST_NULL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && acks_q == 2'd0 && mem_rdata == '0)
         |=> walk_done && walk_fault && !mem_req); // R4

   AST_LEAF_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && acks_q == 2'd0 && mem_rdata != '0)
         |=> mem_req && !walk_done); // R5

   AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      walk_fault |-> walk_done && walk_ppn == '0 && walk_perm == 3'b000 && !walk_dirty); // R7

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      walk_done |=> !walk_done && walk_ready); // R8

   AST_LEAF_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && acks_q == 2'd1) |=> walk_done); // R8

   AST_RESULT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !walk_done |-> walk_ppn == '0 && walk_perm == 3'b000 && !walk_dirty); // R8

endmodule

bind pgtbl_walker pgtbl_walker_chk #(
   .PA_W       (PA_W),
   .VPN_W      (VPN_W),
   .L1_IDX_W   (L1_IDX_W),
   .PAGE_OFS_W (PAGE_OFS_W),
   .ALIGNED    (ALIGNED)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .root_q     (root_q),
   .walk_req   (walk_req),
   .walk_vpn   (walk_vpn),
   .walk_ready (walk_ready),
   .mem_req    (mem_req),
   .mem_addr   (mem_addr),
   .mem_ack    (mem_ack),
   .mem_rdata  (mem_rdata),
   .walk_done  (walk_done),
   .walk_fault (walk_fault),
   .walk_ppn   (walk_ppn),
   .walk_perm  (walk_perm),
   .walk_dirty (walk_dirty)
);

// File: tb/tb_pgtbl_walker.sv
module tb_pgtbl_walker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        root_we = 1'b0;
   logic [31:0] root_wdata = '0;
   logic        walk_req = 1'b0;
   logic [19:0] walk_vpn = '0;
   logic        walk_ready;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = 32'hDEAD_BEEF;
   logic        walk_done;
   logic        walk_fault;
   logic [19:0] walk_ppn;
   logic [2:0]  walk_perm;
   logic        walk_dirty;

   int checks = 0;
   int errors = 0;
   int lat = 0;
   int reads = 0;
   int wait_cnt = 0;
   bit ack_d = 1'b0;
   bit model_on = 1'b0;
   logic [31:0] mem [logic [31:0]];

   always #10 clk = ~clk;

   pgtbl_walker dut (
      .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_wdata(root_wdata),
      .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_ready(walk_ready),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .walk_done(walk_done), .walk_fault(walk_fault), .walk_ppn(walk_ppn),
      .walk_perm(walk_perm), .walk_dirty(walk_dirty)
   );

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // memory responder: waits lat cycles after a request appears, then acks once
   always @(negedge clk) begin
      if (ack_d) begin
         mem_ack   = 1'b0;
         mem_rdata = 32'hDEAD_BEEF;
         wait_cnt  = 0;
         ack_d     = 1'b0;
      end else if (mem_req) begin
         if (wait_cnt >= lat) begin
            mem_ack   = 1'b1;
            mem_rdata = rd(mem_addr);
            ack_d     = 1'b1;
            reads++;
         end else begin
            wait_cnt++;
         end
      end
   end

   // behavioural reference: phase 0 idle, 1 top read, 2 leaf read, 3 report
   int          m_ph;
   logic [31:0] m_root, m_addr;
   logic [19:0] m_vpn;
   logic        m_fault, m_dirty;
   logic [2:0]  m_perm;
   logic [19:0] m_ppn;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph <= 0; m_root <= '0; m_addr <= '0; m_vpn <= '0;
         m_fault <= 0; m_dirty <= 0; m_perm <= 0; m_ppn <= 0;
      end else begin
         if (root_we) m_root <= root_wdata;
         case (m_ph)
            0: if (walk_req) begin
                  m_addr <= m_root + {20'd0, walk_vpn[19:10], 2'b00};
                  m_vpn  <= walk_vpn;
                  m_ph   <= 1;
               end
            1: if (mem_ack) begin
                  if (mem_rdata == 32'h0) begin
                     m_fault <= 1; m_ppn <= 0; m_perm <= 0; m_dirty <= 0; m_ph <= 3;
                  end else begin
                     m_addr <= mem_rdata + {20'd0, m_vpn[9:0], 2'b00};
                     m_ph   <= 2;
                  end
               end
            2: if (mem_ack) begin
                  m_fault <= !mem_rdata[0];
                  m_ppn   <= mem_rdata[0] ? mem_rdata[31:12] : 20'd0;
                  m_perm  <= mem_rdata[0] ? mem_rdata[4:2] : 3'd0;
                  m_dirty <= mem_rdata[0] & mem_rdata[1];
                  m_ph    <= 3;
               end
            default: m_ph <= 0;
         endcase
      end
   end

   always @(negedge clk) begin
      if (model_on && rst_n) begin
         chk(walk_ready == (m_ph == 0), "R1 ready vs model", {31'd0, walk_ready}, {31'd0, m_ph == 0});
         chk(mem_req == (m_ph == 1 || m_ph == 2), "R3 mem_req vs model", {31'd0, mem_req}, {31'd0, m_ph == 1 || m_ph == 2});
         if (m_ph == 1 || m_ph == 2)
            chk(mem_addr == m_addr, "R2/R5 mem_addr vs model", mem_addr, m_addr);
         chk(walk_done == (m_ph == 3), "R8 done vs model", {31'd0, walk_done}, {31'd0, m_ph == 3});
         if (m_ph == 3)
            chk({walk_fault, walk_dirty, walk_perm, walk_ppn} == {m_fault, m_dirty, m_perm, m_ppn},
                "R6 result vs model", {7'd0, walk_fault, walk_dirty, walk_perm, walk_ppn},
                {7'd0, m_fault, m_dirty, m_perm, m_ppn});
         else
            chk({walk_fault, walk_dirty, walk_perm, walk_ppn} == 25'd0, "R8 idle result zero",
                {7'd0, walk_fault, walk_dirty, walk_perm, walk_ppn}, 32'd0);
      end
   end

   task automatic run_walk(input logic [19:0] vpn, input int l, input bit wr_root,
                           input logic [31:0] new_root, input bit interfere,
                           input bit e_fault, input logic [19:0] e_ppn, input logic [2:0] e_perm,
                           input bit e_dirty, input int e_reads, input string tag);
      int guard;
      @(negedge clk);
      lat = l; reads = 0;
      walk_req = 1'b1; walk_vpn = vpn;
      root_we = wr_root; root_wdata = new_root;
      @(negedge clk);
      walk_req = 1'b0; root_we = 1'b0;
      if (interfere) begin
         @(negedge clk);
         walk_req = 1'b1; walk_vpn = 20'h01400;
         @(negedge clk);
         walk_req = 1'b0;
      end
      guard = 0;
      while (!walk_done && guard < 300) begin
         @(negedge clk);
         guard++;
      end
      chk(walk_done, {tag, " done seen"}, {31'd0, walk_done}, 32'd1);
      chk(walk_fault == e_fault, {tag, " fault"}, {31'd0, walk_fault}, {31'd0, e_fault});
      chk(walk_ppn == e_ppn, {tag, " ppn"}, {12'd0, walk_ppn}, {12'd0, e_ppn});
      chk(walk_perm == e_perm, {tag, " perm"}, {29'd0, walk_perm}, {29'd0, e_perm});
      chk(walk_dirty == e_dirty, {tag, " dirty"}, {31'd0, walk_dirty}, {31'd0, e_dirty});
      chk(reads == e_reads, {tag, " read count"}, reads, e_reads);
      @(negedge clk);
      chk(walk_ready && !walk_done, "R8 ready after done, single pulse",
          {30'd0, walk_ready, walk_done}, 32'd2);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // root A tables
      mem[32'h0001_0004] = 32'h0002_0000;
      mem[32'h0002_000C] = 32'hABCDE017;   // v d r x
      mem[32'h0002_0FFC] = 32'h1234500D;   // v r w
      mem[32'h0002_001C] = 32'hFFFFF01E;   // invalid, other bits set
      mem[32'h0001_0FFC] = 32'h0003_0000;
      mem[32'h0003_0FFC] = 32'h00001011;   // v x
      // root B tables
      mem[32'h0004_0004] = 32'h0005_0000;
      mem[32'h0005_000C] = 32'h55555005;   // v r

      repeat (2) @(negedge clk);
      chk(walk_ready && !mem_req && !walk_done, "R10 reset state",
          {29'd0, walk_ready, mem_req, walk_done}, 32'd4);
      rst_n = 1'b1;
      model_on = 1'b1;
      @(negedge clk);
      root_we = 1'b1; root_wdata = 32'h0001_0000;   // R9 load base
      @(negedge clk);
      root_we = 1'b0;

      run_walk(20'h00403, 0, 0, 0, 0, 0, 20'hABCDE, 3'b101, 1, 2, "R6 mapped lat0");
      run_walk(20'h007FF, 3, 0, 0, 0, 0, 20'h12345, 3'b011, 0, 2, "R3 R5 slow leaf idx max");
      run_walk(20'h01400, 2, 0, 0, 0, 1, 20'h0, 3'b000, 0, 1, "R4 null top word");
      run_walk(20'h00407, 1, 0, 0, 0, 1, 20'h0, 3'b000, 0, 2, "R7 invalid leaf");
      run_walk(20'hFFFFF, 1, 0, 0, 0, 0, 20'h00001, 3'b100, 0, 2, "R2 top idx max");
      run_walk(20'h00403, 4, 0, 0, 1, 0, 20'hABCDE, 3'b101, 1, 2, "R1 busy request ignored");
      run_walk(20'h00403, 2, 1, 32'h0004_0000, 0, 0, 20'hABCDE, 3'b101, 1, 2, "R9 old base on same edge");
      run_walk(20'h00403, 0, 0, 0, 0, 0, 20'h55555, 3'b001, 0, 2, "R9 new base later");

      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule